// File: doc/BRIEF.md
# Three-Phase Gate Control with Interlock and Dead Time

This block turns per-phase switching commands into gate enables for the three half-bridges of an inverter. Each phase has a high-side command, which is active high, and a low-side command, which is active low. From these the block derives a high-side and a low-side gate enable. A phase never conducts on both sides. When both sides are requested, both gates are held off. Any gate turning on must first wait a programmable dead time, counted from the moment the opposite gate of that phase turned off. This also works when both commands of a phase are driven by one signal.

Every gate is forced off by any of these conditions:
- a shared active-low shutdown line;
- an overcurrent fault input;
- a low-side supply undervoltage flag.

A per-phase high-side supply undervoltage flag disables only that phase's high gate. A fault trip kills the gates directly, without waiting for the shutdown line to fall. It also latches a pull-down request for the open-drain shutdown line. That request is released only once the line has been seen low and the fault has cleared.

All inputs are asynchronous levels from comparators. They pass through two-flop synchronizers before the registered gate logic.

Top module: `inverter_gate_ctl`

## Requirements
- R1: While reset is high and on the first cycle after it, every gate output and the pull-down output are 0.
- R2: With shutdown high and no fault or undervoltage, a phase with high command 1 and low command (active low) 1 drives only its high gate. High command 0 with low command 0 drives only its low gate. High 0 with low 1 drives neither.
- R3: A phase with high command 1 and low command 0 (both requested) drives neither gate.
- R4: A gate turns on no sooner than DEAD_CYC+1 clock cycles after the opposite gate of the same phase turned off. A request arriving inside that window is held off until the window ends, then granted.
- R5: With both commands of a phase tied to one signal, the gates alternate complementarily, and exactly DEAD_CYC+1 cycles with both gates off separate every transition.
- R6: While the synchronized shutdown input (active low) is 0, every gate is off. After it returns high, gates follow the commands again.
- R7: A fault input high turns every gate off and asserts the pull-down output on the third rising edge after it is applied, independent of the shutdown input.
- R8: Once set, the pull-down output stays 1 while the shutdown input reads 1. It clears three edges after the shutdown input reads 0 with the fault input low, and stays set while the fault input is still high.
- R9: A low-side supply undervoltage flag (1 = undervoltage) turns off both gates of all phases.
- R10: A high-side supply undervoltage flag of a phase (1 = undervoltage) turns off only that phase's high gate and leaves its low gate and other phases unaffected.
- R11: A command change that the dead time allows appears at the gate outputs on the third rising edge after it is applied (two synchronizer stages plus the output register), not on the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | PHASES | High-side commands, active high, bit i = phase i |
| lo_cmd_n | input | PHASES | Low-side commands, active low |
| sd_n | input | 1 | Shared shutdown line level, active low |
| fault | input | 1 | Overcurrent comparator output, 1 = trip |
| uv_main | input | 1 | Low-side supply undervoltage, 1 = under |
| uv_boot | input | PHASES | Per-phase high-side supply undervoltage, 1 = under |
| gate_hi | output | PHASES | High-side gate enables |
| gate_lo | output | PHASES | Low-side gate enables |
| sd_pull | output | 1 | Open-drain pull-down request for the shutdown line |

## Verification
The assertions check several properties on every cycle:
- no phase ever has both gates on;
- a gate rises only when its partner was off on the previous cycle;
- the interlock, shutdown, fault and undervoltage conditions clear the gates one edge after they are seen;
- the pull-down latch holds and releases as R8 states.

Some behaviour shows up only in the bench's timed scenarios:
- the exact length of the dead-time gap;
- a request held off inside the window and then granted;
- the tied-command alternation;
- the three-edge latency;
- gates resuming after shutdown, fault or undervoltage clears.

// File: rtl/gate_ctl_pkg.sv
package gate_ctl_pkg;
    // number of synchronized single-bit controls shared by all phases
    localparam int SHARED_CTRL = 3;

    // computes the counter width needed to hold a dead-time load value
    function automatic int cnt_width(input int dead);
        return (dead < 1) ? 1 : $clog2(dead + 1);
    endfunction
endpackage

// File: rtl/gc_sync.sv
module gc_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.s1 <= RST_VAL;
            st_q.s2 <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.s2;
endmodule

// File: rtl/gc_fault.sv
module gc_fault (
    input  logic clk,
    input  logic rst,
    input  logic fault_s,
    input  logic sd_s,
    output logic kill,
    output logic pull
);
    logic latch_d, latch_q;

    always_comb begin
        // set by a trip, held until the shutdown line is seen low
        latch_d = fault_s | (latch_q & sd_s);
    end

    always_ff @(posedge clk) begin
        if (rst) latch_q <= 1'b0;
        else     latch_q <= latch_d;
    end

    // fast path: the synchronized trip kills gates before the latch is set
    assign kill = fault_s | latch_q;
    assign pull = latch_q;

    a_r7_trip_sets_pull: assert property (@(posedge clk) disable iff (rst)
        fault_s |=> pull);
    a_r8_hold_while_line_high: assert property (@(posedge clk) disable iff (rst)
        (pull && sd_s) |=> pull);
    a_r8_release_on_low: assert property (@(posedge clk) disable iff (rst)
        (!sd_s && !fault_s) |=> !pull);
endmodule

// File: rtl/gc_phase.sv
module gc_phase
    import gate_ctl_pkg::*;
#(
    parameter int DEAD_CYC = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    input  logic enable,
    input  logic hi_ok,
    output logic gate_hi,
    output logic gate_lo
);
    localparam int CW = cnt_width(DEAD_CYC);
    localparam logic [CW-1:0] LOAD = CW'(DEAD_CYC);

    typedef struct packed {
        logic          hi;
        logic          lo;
        logic [CW-1:0] cnt;
    } ph_t;

    ph_t  st_d, st_q;
    logic req_hi, req_lo, free;

    always_comb begin
        req_hi = enable & hi_ok & hi_cmd & lo_cmd_n;
        req_lo = enable & ~hi_cmd & ~lo_cmd_n;
        free   = (st_q.cnt == '0);

        st_d.hi = req_hi & (st_q.hi | (free & ~st_q.lo));
        st_d.lo = req_lo & (st_q.lo | (free & ~st_q.hi));

        if ((st_q.hi & ~st_d.hi) | (st_q.lo & ~st_d.lo))
            st_d.cnt = LOAD;
        else if (!free)
            st_d.cnt = st_q.cnt - CW'(1);
        else
            st_d.cnt = st_q.cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.hi  <= 1'b0;
            st_q.lo  <= 1'b0;
            st_q.cnt <= LOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_hi = st_q.hi;
    assign gate_lo = st_q.lo;

    a_r3_never_both_on: assert property (@(posedge clk) disable iff (rst)
        !(gate_hi && gate_lo));
    a_r3_interlock_off: assert property (@(posedge clk) disable iff (rst)
        (hi_cmd && !lo_cmd_n) |=> (!gate_hi && !gate_lo));
    a_r4_hi_rise_after_lo_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_hi) |-> $past(!gate_lo));
    a_r4_lo_rise_after_hi_off: assert property (@(posedge clk) disable iff (rst)
        $rose(gate_lo) |-> $past(!gate_hi));
    a_r10_boot_uv_hi_off: assert property (@(posedge clk) disable iff (rst)
        !hi_ok |=> !gate_hi);
endmodule

// File: rtl/inverter_gate_ctl.sv
module inverter_gate_ctl
    import gate_ctl_pkg::*;
#(
    parameter int PHASES   = 3,
    parameter int DEAD_CYC = 60
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PHASES-1:0] hi_cmd,
    input  logic [PHASES-1:0] lo_cmd_n,
    input  logic              sd_n,
    input  logic              fault,
    input  logic              uv_main,
    input  logic [PHASES-1:0] uv_boot,
    output logic [PHASES-1:0] gate_hi,
    output logic [PHASES-1:0] gate_lo,
    output logic              sd_pull
);
    localparam int SW = 3 * PHASES + SHARED_CTRL;
    // order: {uv_boot, uv_main, fault, sd_n, lo_cmd_n, hi_cmd}; safe values in reset
    localparam logic [SW-1:0] SYNC_RST =
        {{PHASES{1'b1}}, 1'b1, 1'b0, 1'b0, {PHASES{1'b1}}, {PHASES{1'b0}}};

    logic [SW-1:0]     raw, synced;
    logic [PHASES-1:0] hi_s, lo_n_s, uv_boot_s;
    logic              sd_s, fault_s, uv_main_s;
    logic              kill, enable;

    assign raw = {uv_boot, uv_main, fault, sd_n, lo_cmd_n, hi_cmd};

    gc_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_in(raw),
        .sync_out(synced)
    );

    assign hi_s      = synced[PHASES-1:0];
    assign lo_n_s    = synced[2*PHASES-1:PHASES];
    assign sd_s      = synced[2*PHASES];
    assign fault_s   = synced[2*PHASES+1];
    assign uv_main_s = synced[2*PHASES+2];
    assign uv_boot_s = synced[SW-1:2*PHASES+3];

    gc_fault u_fault (
        .clk    (clk),
        .rst    (rst),
        .fault_s(fault_s),
        .sd_s   (sd_s),
        .kill   (kill),
        .pull   (sd_pull)
    );

    assign enable = sd_s & ~kill & ~uv_main_s;

    for (genvar p = 0; p < PHASES; p++) begin : g_phase
        gc_phase #(.DEAD_CYC(DEAD_CYC)) u_phase (
            .clk     (clk),
            .rst     (rst),
            .hi_cmd  (hi_s[p]),
            .lo_cmd_n(lo_n_s[p]),
            .enable  (enable),
            .hi_ok   (~uv_boot_s[p]),
            .gate_hi (gate_hi[p]),
            .gate_lo (gate_lo[p])
        );
    end

    a_r6_shutdown_all_off: assert property (@(posedge clk) disable iff (rst)
        !sd_s |=> (gate_hi == '0 && gate_lo == '0));
    a_r7_fault_all_off: assert property (@(posedge clk) disable iff (rst)
        fault_s |=> (gate_hi == '0 && gate_lo == '0));
    a_r9_main_uv_all_off: assert property (@(posedge clk) disable iff (rst)
        uv_main_s |=> (gate_hi == '0 && gate_lo == '0));
    a_r1_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (gate_hi == '0 && gate_lo == '0 && !sd_pull));
endmodule

// File: tb/tb_inverter_gate_ctl.sv
module tb_inverter_gate_ctl;
    localparam int P  = 3;
    localparam int DT = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [P-1:0] hi_cmd = '0, lo_cmd_n = '1, uv_boot = '0;
    logic         sd_n = 1'b1, fault = 1'b0, uv_main = 1'b0;
    logic [P-1:0] gate_hi, gate_lo;
    logic         sd_pull;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic [P-1:0] gh;
        logic [P-1:0] gl;
        logic         pl;
        string        tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    inverter_gate_ctl #(.PHASES(P), .DEAD_CYC(DT)) dut (
        .clk(clk), .rst(rst), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
        .sd_n(sd_n), .fault(fault), .uv_main(uv_main), .uv_boot(uv_boot),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .sd_pull(sd_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // driver side: queue an expectation for the current negedge
    task automatic expect_now(input logic [P-1:0] gh, input logic [P-1:0] gl,
                              input logic pl, input string tag);
        exp_t e;
        e.gh = gh; e.gl = gl; e.pl = pl; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check_val(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_ph(input int i, input logic h, input logic ln);
        hi_cmd[i]   = h;
        lo_cmd_n[i] = ln;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: compares every queued expectation just after the negedge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_chk++;
                if (gate_hi !== e.gh || gate_lo !== e.gl || sd_pull !== e.pl) begin
                    n_fail++;
                    $display("FAIL %s: actual hi=%b lo=%b pull=%b expected hi=%b lo=%b pull=%b",
                             e.tag, gate_hi, gate_lo, sd_pull, e.gh, e.gl, e.pl);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    // counts negedges with both gates of phase 2 off until the target gate rises
    task automatic gap_count(input bit want_lo, output int cnt);
        cnt = 0;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            #1;
            if (want_lo ? gate_lo[2] : gate_hi[2]) break;
            if (!gate_hi[2] && !gate_lo[2]) cnt++;
        end
    endtask

    initial begin
        int gap;
        tick(3);
        expect_now(3'b000, 3'b000, 1'b0, "R1 in reset");
        rst = 1'b0;
        tick(1);
        expect_now(3'b000, 3'b000, 1'b0, "R1 after reset");
        tick(DT + 10);

        // R2 / R11: phase 0 high side, three-edge latency
        set_ph(0, 1'b1, 1'b1);
        tick(2);
        expect_now(3'b000, 3'b000, 1'b0, "R11 not yet at edge 2");
        tick(1);
        expect_now(3'b001, 3'b000, 1'b0, "R11 R2 high gate at edge 3");

        // R2: phase 1 low side
        set_ph(1, 1'b0, 1'b0);
        tick(5);
        expect_now(3'b001, 3'b010, 1'b0, "R2 low gate only");

        // R3: phase 2 both requested
        set_ph(2, 1'b1, 1'b0);
        tick(5);
        expect_now(3'b001, 3'b010, 1'b0, "R3 interlock both off");

        // R4: phase 0 releases high, asks for low inside the window
        set_ph(0, 1'b0, 1'b1);
        tick(2);
        set_ph(0, 1'b0, 1'b0);
        tick(DT + 1);
        expect_now(3'b000, 3'b010, 1'b0, "R4 low held in window");
        tick(1);
        expect_now(3'b000, 3'b011, 1'b0, "R4 low granted after window");

        // R5: phase 2 commands tied to one signal
        set_ph(2, 1'b1, 1'b1);
        tick(5);
        expect_now(3'b100, 3'b011, 1'b0, "R5 tied high");
        tick(1);
        set_ph(2, 1'b0, 1'b0);
        gap_count(1'b1, gap);
        check_val("R5 gap high to low", gap, DT + 1);
        tick(1);
        set_ph(2, 1'b1, 1'b1);
        gap_count(1'b0, gap);
        check_val("R5 gap low to high", gap, DT + 1);
        tick(3);
        expect_now(3'b100, 3'b011, 1'b0, "R5 tied back high");

        // R10: high-side undervoltage on phases 2 and 0
        uv_boot = 3'b101;
        tick(5);
        expect_now(3'b000, 3'b011, 1'b0, "R10 only high gates off");
        uv_boot = 3'b000;
        tick(DT + 8);
        expect_now(3'b100, 3'b011, 1'b0, "R10 recovered");

        // R9: low-side undervoltage
        uv_main = 1'b1;
        tick(5);
        expect_now(3'b000, 3'b000, 1'b0, "R9 all off");
        uv_main = 1'b0;
        tick(DT + 8);
        expect_now(3'b100, 3'b011, 1'b0, "R9 recovered");

        // R6: shutdown line
        sd_n = 1'b0;
        tick(5);
        expect_now(3'b000, 3'b000, 1'b0, "R6 shutdown all off");
        sd_n = 1'b1;
        tick(2);
        expect_now(3'b000, 3'b000, 1'b0, "R6 still off before sync");
        tick(DT + 8);
        expect_now(3'b100, 3'b011, 1'b0, "R6 resumed");

        // R7: fault trip with shutdown line still high
        fault = 1'b1;
        tick(2);
        expect_now(3'b100, 3'b011, 1'b0, "R7 not yet at edge 2");
        tick(1);
        expect_now(3'b000, 3'b000, 1'b1, "R7 off and pull at edge 3");
        fault = 1'b0;
        tick(10);
        expect_now(3'b000, 3'b000, 1'b1, "R8 pull held while line high");
        sd_n = 1'b0;
        tick(2);
        expect_now(3'b000, 3'b000, 1'b1, "R8 pull before line seen low");
        tick(1);
        expect_now(3'b000, 3'b000, 1'b0, "R8 pull released");
        sd_n = 1'b1;
        tick(DT + 8);
        expect_now(3'b100, 3'b011, 1'b0, "R8 gates back after release");

        // R8: fault persisting while the line is low keeps the pull-down
        fault = 1'b1;
        sd_n  = 1'b0;
        tick(8);
        expect_now(3'b000, 3'b000, 1'b1, "R8 pull kept during fault");
        fault = 1'b0;
        tick(5);
        expect_now(3'b000, 3'b000, 1'b0, "R8 pull released after fault");
        sd_n = 1'b1;
        tick(DT + 8);
        expect_now(3'b100, 3'b011, 1'b0, "R6 final resume");

        tick(3);
        report();
    end
endmodule